// File: doc/BRIEF.md
# Ethernet DMA Interrupt Register Block

This block gathers interrupt events from the receive and transmit descriptor engines of an Ethernet DMA and latches them into sticky status bits. An enable register masks the status bits. One registered interrupt line goes high while any enabled status bit is set. Software uses a small word-wide register port with four registers:

- a read-only status view
- a read/write enable mask
- a write-one-to-clear register
- a write-one-to-set register

The datapath supplies the events:

- fatal/nonfatal overrun (receive) and underrun (transmit) indications
- per-cause error flags
- descriptor completions with the descriptor's interrupt request flag
- the produce and consume indices of each queue
- a wake-up pulse

The "finished" bit of a queue is raised by the block itself when the queue's produce and consume indices come together. A software interrupt bit has no hardware source. Only a write to the set register can raise it.

Top module: `eth_dma_irq_regs`

## Requirements
- R1: After reset, the status bits, the enable bits, the interrupt output and the read data are all 0.
- R2: Register map by byte offset: 0x0 status, 0x4 enable, 0x8 clear, 0xC set.
  - Status is read-only, and a write to 0x0 changes nothing.
  - Enable reads back what was written.
  - Writing 1s to 0x8 clears those status bits.
  - Writing 1s to 0xC sets those status bits.
  - Reads of 0x8 and 0xC return 0.
  - Read data shows the register addressed in the previous cycle.
- R3: Receive finished (bit 2) and transmit finished (bit 6) are set only in the cycle where that queue's produce index becomes equal to its consume index after being unequal. This includes the case where the index wraps. Equality that persists does not set the bit again. Equality present at reset does not set it.
- R4: Receive done (bit 3) and transmit done (bit 7) are set by a descriptor completion only when that descriptor's interrupt flag is 1.
- R5: Receive overrun (bit 0) and transmit underrun (bit 4) are set only when the overrun or underrun indication carries the fatal qualifier.
- R6: Receive error (bit 1) is set by any of the six receive error flags or by any receive overrun, fatal or not. The flag order is: [0] alignment, [1] range, [2] length, [3] symbol, [4] CRC, [5] no descriptor. Transmit error (bit 5) is set by any of the four transmit error flags or by any transmit underrun. The flag order is: [0] late collision, [1] excessive collision, [2] excessive defer, [3] no descriptor.
- R7: Software interrupt (bit 12) is set only through the set register. Wake-up (bit 13) is set by the wake-up event input.
- R8: Status bits 11:8 and 31:14 read as 0 and cannot be set. Enable bits 11:8 and 31:14 ignore writes and read as 0.
- R9: The interrupt output is registered. It is 1 in the cycle after some status bit and its enable bit are both 1, and 0 in the cycle after no such pair exists.
- R10: A hardware event and a clear write to the same bit in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| rx_overrun | input | 1 | Receive overrun indication |
| rx_overrun_fatal | input | 1 | Qualifies rx_overrun as fatal |
| rx_err_flags | input | 6 | Receive error causes |
| rx_desc_done | input | 1 | Receive descriptor completed |
| rx_desc_irq | input | 1 | Interrupt flag of the completed receive descriptor |
| rx_prod_idx | input | IDX_W | Receive produce index |
| rx_cons_idx | input | IDX_W | Receive consume index |
| tx_underrun | input | 1 | Transmit underrun indication |
| tx_underrun_fatal | input | 1 | Qualifies tx_underrun as fatal |
| tx_err_flags | input | 4 | Transmit error causes |
| tx_desc_done | input | 1 | Transmit descriptor completed |
| tx_desc_irq | input | 1 | Interrupt flag of the completed transmit descriptor |
| tx_prod_idx | input | IDX_W | Transmit produce index |
| tx_cons_idx | input | IDX_W | Transmit consume index |
| wake_event | input | 1 | Wake-up event |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with IDX_W set to 4 and ADDR_W left at 4. The narrow index lets the transmit test wrap its produce index from 15 to 0, where it meets a consume index of 0. This exercises the finished-bit edge detector across a wrap with only a few cycles of stimulus. The default ADDR_W keeps all four register offsets reachable, and writes with every bit set show that the unused bit positions are masked.

// File: rtl/eth_irq_pkg.sv
// Package: status bit positions, valid-bit mask and register offsets shared by
// the interrupt register block. Assumes a 32-bit register word.
package eth_irq_pkg;
    localparam int REG_W = 32;

    localparam int B_RX_OVR  = 0;
    localparam int B_RX_ERR  = 1;
    localparam int B_RX_FIN  = 2;
    localparam int B_RX_DONE = 3;
    localparam int B_TX_UND  = 4;
    localparam int B_TX_ERR  = 5;
    localparam int B_TX_FIN  = 6;
    localparam int B_TX_DONE = 7;
    localparam int B_SOFT    = 12;
    localparam int B_WAKE    = 13;

    localparam logic [REG_W-1:0] VALID_MASK = 32'h0000_30FF;

    localparam logic [3:0] OFF_STATUS = 4'h0;
    localparam logic [3:0] OFF_ENABLE = 4'h4;
    localparam logic [3:0] OFF_CLEAR  = 4'h8;
    localparam logic [3:0] OFF_SET    = 4'hC;

    // Per-queue event bundle produced by the queue event detector.
    typedef struct packed {
        logic done;
        logic finished;
        logic error;
        logic fatal;
    } queue_ev_t;
endpackage

// File: rtl/eth_irq_queue_events.sv
// Module: turns one queue's raw datapath indications into four event pulses
// (fatal, error, finished, done). Assumes the indices change synchronously to
// clk and that an empty queue (indices equal) is the state at reset.
module eth_irq_queue_events
    import eth_irq_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int ERR_N = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xrun,
    input  logic             xrun_fatal,
    input  logic [ERR_N-1:0] err_flags,
    input  logic             desc_done,
    input  logic             desc_irq,
    input  logic [IDX_W-1:0] prod_idx,
    input  logic [IDX_W-1:0] cons_idx,
    output queue_ev_t        ev
);
    logic idx_equal;
    logic idx_equal_q;

    // Compare produce and consume indices.
    assign idx_equal = (prod_idx == cons_idx);

    // Remember last cycle's equality; empty queue assumed at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_equal_q <= 1'b1;
        else        idx_equal_q <= idx_equal;
    end

    // Derive the four event pulses for this cycle.
    always_comb begin
        ev.fatal    = xrun & xrun_fatal;
        ev.error    = (|err_flags) | xrun;
        ev.finished = idx_equal & ~idx_equal_q;
        ev.done     = desc_done & desc_irq;
    end

    // R3: a finished pulse is never followed by another in the next cycle
    a_r3_single_finish: assert property (@(posedge clk) disable iff (!rst_n)
        ev.finished |=> !ev.finished);
endmodule

// File: rtl/eth_irq_status_bank.sv
// Module: sticky status bits. Each valid bit is set by a hardware event or a
// set write and cleared by a clear write; set sources win over clear.
// Assumes set/clear masks are already qualified by the write strobe.
module eth_irq_status_bank
    import eth_irq_pkg::*;
#(
    parameter int                W     = REG_W,
    parameter logic [W-1:0]      VALID = VALID_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_ev,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (VALID[i]) begin : g_live
            // Sticky bit: set sources have priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    status[i] <= 1'b0;
                else if (hw_ev[i] || set_mask[i])
                    status[i] <= 1'b1;
                else if (clr_mask[i])
                    status[i] <= 1'b0;
            end

            // R10: an event or set in the same cycle as a clear leaves the bit set
            a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_ev[i] || set_mask[i]) |=> status[i]);

            // R2: a clear write with no competing source drops the bit
            a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_mask[i] && !hw_ev[i] && !set_mask[i]) |=> !status[i]);
        end else begin : g_dead
            // Unused position: constant zero flop, inputs ignored.
            always_ff @(posedge clk) begin
                if (!rst_n) status[i] <= 1'b0;
                else        status[i] <= 1'b0 & (hw_ev[i] | set_mask[i] | clr_mask[i]);
            end
        end
    end
endmodule

// File: rtl/eth_irq_reg_port.sv
// Module: register port. Decodes the byte address, holds the enable mask,
// produces write-one set/clear masks and registers read data one cycle after
// the address. Assumes single-cycle writes with reg_wr high for one cycle.
module eth_irq_reg_port
    import eth_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [REG_W-1:0]  status,
    output logic [REG_W-1:0]  enable,
    output logic [REG_W-1:0]  set_mask,
    output logic [REG_W-1:0]  clr_mask,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);
    localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFF_SET);

    logic [REG_W-1:0] wdata_ok;

    // Drop writes to unused bit positions.
    assign wdata_ok = reg_wdata & VALID_MASK;

    // One-cycle set and clear masks from writes to their offsets.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (reg_wr && reg_addr == A_SET)   set_mask = wdata_ok;
        if (reg_wr && reg_addr == A_CLEAR) clr_mask = wdata_ok;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                         enable <= '0;
        else if (reg_wr && reg_addr == A_ENABLE) enable <= wdata_ok;
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else begin
            unique case (reg_addr)
                A_STATUS: reg_rdata <= status;
                A_ENABLE: reg_rdata <= enable;
                default:  reg_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/eth_dma_irq_regs.sv
// Module: top of the Ethernet DMA interrupt register block. Builds the status
// event vector from the two queue detectors and the wake-up input, keeps the
// sticky status, and drives a registered interrupt output.
// Assumes all inputs are synchronous to clk.
module eth_dma_irq_regs
    import eth_irq_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int ADDR_W   = 4,
    parameter int RX_ERR_N = 6,
    parameter int TX_ERR_N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                rx_overrun,
    input  logic                rx_overrun_fatal,
    input  logic [RX_ERR_N-1:0] rx_err_flags,
    input  logic                rx_desc_done,
    input  logic                rx_desc_irq,
    input  logic [IDX_W-1:0]    rx_prod_idx,
    input  logic [IDX_W-1:0]    rx_cons_idx,
    input  logic                tx_underrun,
    input  logic                tx_underrun_fatal,
    input  logic [TX_ERR_N-1:0] tx_err_flags,
    input  logic                tx_desc_done,
    input  logic                tx_desc_irq,
    input  logic [IDX_W-1:0]    tx_prod_idx,
    input  logic [IDX_W-1:0]    tx_cons_idx,
    input  logic                wake_event,
    output logic                irq_out
);
    queue_ev_t        rx_ev, tx_ev;
    logic [REG_W-1:0] hw_ev, set_mask, clr_mask, status, enable;
    logic             irq_any;

    eth_irq_queue_events #(.IDX_W(IDX_W), .ERR_N(RX_ERR_N)) u_rx_ev (
        .clk(clk), .rst_n(rst_n),
        .xrun(rx_overrun), .xrun_fatal(rx_overrun_fatal), .err_flags(rx_err_flags),
        .desc_done(rx_desc_done), .desc_irq(rx_desc_irq),
        .prod_idx(rx_prod_idx), .cons_idx(rx_cons_idx), .ev(rx_ev)
    );

    eth_irq_queue_events #(.IDX_W(IDX_W), .ERR_N(TX_ERR_N)) u_tx_ev (
        .clk(clk), .rst_n(rst_n),
        .xrun(tx_underrun), .xrun_fatal(tx_underrun_fatal), .err_flags(tx_err_flags),
        .desc_done(tx_desc_done), .desc_irq(tx_desc_irq),
        .prod_idx(tx_prod_idx), .cons_idx(tx_cons_idx), .ev(tx_ev)
    );

    // Place queue and wake-up events at their status bit positions.
    always_comb begin
        hw_ev            = '0;
        hw_ev[B_RX_OVR]  = rx_ev.fatal;
        hw_ev[B_RX_ERR]  = rx_ev.error;
        hw_ev[B_RX_FIN]  = rx_ev.finished;
        hw_ev[B_RX_DONE] = rx_ev.done;
        hw_ev[B_TX_UND]  = tx_ev.fatal;
        hw_ev[B_TX_ERR]  = tx_ev.error;
        hw_ev[B_TX_FIN]  = tx_ev.finished;
        hw_ev[B_TX_DONE] = tx_ev.done;
        hw_ev[B_WAKE]    = wake_event;
    end

    eth_irq_reg_port #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .status(status), .enable(enable),
        .set_mask(set_mask), .clr_mask(clr_mask), .reg_rdata(reg_rdata)
    );

    eth_irq_status_bank #(.W(REG_W), .VALID(VALID_MASK)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .hw_ev(hw_ev), .set_mask(set_mask), .clr_mask(clr_mask), .status(status)
    );

    // Any enabled status bit requests an interrupt.
    assign irq_any = |(status & enable);

    // Register the interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= irq_any;
    end

    // R9: an enabled pending bit raises the line one cycle later
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |=> irq_out);

    // R9: with nothing enabled and pending the line is low one cycle later
    a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_any |=> !irq_out);
endmodule

// File: tb/sim_eth_dma_irq_regs.sv
// Directed bench: one task for each scenario, each checking its own results.
module sim_eth_dma_irq_regs;
    localparam int IDX_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_overrun = 0, rx_overrun_fatal = 0;
    logic [5:0]  rx_err_flags = '0;
    logic        rx_desc_done = 0, rx_desc_irq = 0;
    logic [IDX_W-1:0] rx_prod_idx = '0, rx_cons_idx = '0;
    logic        tx_underrun = 0, tx_underrun_fatal = 0;
    logic [3:0]  tx_err_flags = '0;
    logic        tx_desc_done = 0, tx_desc_irq = 0;
    logic [IDX_W-1:0] tx_prod_idx = '0, tx_cons_idx = '0;
    logic        wake_event = 0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    eth_dma_irq_regs #(.IDX_W(IDX_W), .ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_overrun(rx_overrun), .rx_overrun_fatal(rx_overrun_fatal), .rx_err_flags(rx_err_flags),
        .rx_desc_done(rx_desc_done), .rx_desc_irq(rx_desc_irq),
        .rx_prod_idx(rx_prod_idx), .rx_cons_idx(rx_cons_idx),
        .tx_underrun(tx_underrun), .tx_underrun_fatal(tx_underrun_fatal), .tx_err_flags(tx_err_flags),
        .tx_desc_done(tx_desc_done), .tx_desc_irq(tx_desc_irq),
        .tx_prod_idx(tx_prod_idx), .tx_cons_idx(tx_cons_idx),
        .wake_event(wake_event), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b0;
        @(posedge clk);
        #1 v = reg_rdata;
    endtask

    task automatic expect_status(input string req, input logic [31:0] exp);
        logic [31:0] v;
        rd(4'h0, v);
        check(req, v, exp);
    endtask

    task automatic clear_all();
        wr(4'h8, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'd0, irq_out}, 32'd0);
        check("R1 rdata", reg_rdata, 32'd0);
        rd(4'h0, v); check("R1 status", v, 32'd0);
        rd(4'h4, v); check("R1 enable", v, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); check("R8 enable unused bits", v, 32'h0000_30FF);
        wr(4'h4, 32'h0000_0021);
        rd(4'h4, v); check("R2 enable readback", v, 32'h0000_0021);
        wr(4'h4, 32'h0);
        wr(4'h0, 32'hFFFF_FFFF);
        expect_status("R2 status read-only", 32'h0);
        wr(4'hC, 32'hFFFF_FFFF);
        expect_status("R8 set all valid bits", 32'h0000_30FF);
        rd(4'hC, v); check("R2 set reads zero", v, 32'h0);
        rd(4'h8, v); check("R2 clear reads zero", v, 32'h0);
        wr(4'h8, 32'h0000_1001);
        expect_status("R2 clear selected", 32'h0000_20FE);
        clear_all();
        expect_status("R2 clear all", 32'h0);
    endtask

    task automatic t_soft_wake();
        wr(4'hC, 32'h0000_1000);
        expect_status("R7 software bit via set", 32'h0000_1000);
        clear_all();
        @(negedge clk); wake_event = 1'b1;
        @(negedge clk); wake_event = 1'b0;
        expect_status("R7 wake-up bit", 32'h0000_2000);
        clear_all();
    endtask

    task automatic t_overrun();
        @(negedge clk); rx_overrun = 1'b1; rx_overrun_fatal = 1'b0;
        @(negedge clk); rx_overrun = 1'b0;
        expect_status("R5 nonfatal overrun (R6 error only)", 32'h0000_0002);
        clear_all();
        @(negedge clk); rx_overrun = 1'b1; rx_overrun_fatal = 1'b1;
        @(negedge clk); rx_overrun = 1'b0; rx_overrun_fatal = 1'b0;
        expect_status("R5 fatal overrun", 32'h0000_0003);
        clear_all();
        @(negedge clk); tx_underrun = 1'b1; tx_underrun_fatal = 1'b0;
        @(negedge clk); tx_underrun = 1'b0;
        expect_status("R5 nonfatal underrun", 32'h0000_0020);
        clear_all();
        @(negedge clk); tx_underrun = 1'b1; tx_underrun_fatal = 1'b1;
        @(negedge clk); tx_underrun = 1'b0; tx_underrun_fatal = 1'b0;
        expect_status("R5 fatal underrun", 32'h0000_0030);
        clear_all();
    endtask

    task automatic t_errors();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); rx_err_flags = 6'(1 << i);
            @(negedge clk); rx_err_flags = '0;
            expect_status($sformatf("R6 rx error flag %0d", i), 32'h0000_0002);
            clear_all();
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); tx_err_flags = 4'(1 << i);
            @(negedge clk); tx_err_flags = '0;
            expect_status($sformatf("R6 tx error flag %0d", i), 32'h0000_0020);
            clear_all();
        end
    endtask

    task automatic t_done();
        @(negedge clk); rx_desc_done = 1'b1; rx_desc_irq = 1'b0;
                        tx_desc_done = 1'b1; tx_desc_irq = 1'b0;
        @(negedge clk); rx_desc_done = 1'b0; tx_desc_done = 1'b0;
        expect_status("R4 done without flag", 32'h0);
        @(negedge clk); rx_desc_done = 1'b1; rx_desc_irq = 1'b1;
        @(negedge clk); rx_desc_done = 1'b0; rx_desc_irq = 1'b0;
        expect_status("R4 rx done with flag", 32'h0000_0008);
        clear_all();
        @(negedge clk); tx_desc_done = 1'b1; tx_desc_irq = 1'b1;
        @(negedge clk); tx_desc_done = 1'b0; tx_desc_irq = 1'b0;
        expect_status("R4 tx done with flag", 32'h0000_0080);
        clear_all();
    endtask

    task automatic t_finished();
        expect_status("R3 equal at reset gives nothing", 32'h0);
        @(negedge clk); rx_prod_idx = 4'd3;
        repeat (3) @(negedge clk);
        expect_status("R3 unequal gives nothing", 32'h0);
        @(negedge clk); rx_cons_idx = 4'd3;
        expect_status("R3 rx transition to equal", 32'h0000_0004);
        clear_all();
        repeat (3) @(negedge clk);
        expect_status("R3 steady equal no retrigger", 32'h0);
        @(negedge clk); tx_prod_idx = 4'd15;
        repeat (2) @(negedge clk);
        @(negedge clk); tx_prod_idx = 4'd0;
        expect_status("R3 tx wrap to equal", 32'h0000_0040);
        clear_all();
    endtask

    task automatic t_irq();
        wr(4'h4, 32'h0000_2000);
        @(negedge clk); wake_event = 1'b1;
        @(negedge clk); wake_event = 1'b0;
        check("R9 irq not yet (registered)", {31'd0, irq_out}, 32'd0);
        @(posedge clk); #1;
        check("R9 irq one cycle after status", {31'd0, irq_out}, 32'd1);
        wr(4'h8, 32'h0000_2000);
        @(posedge clk); #1;
        check("R9 irq drops after clear", {31'd0, irq_out}, 32'd0);
        wr(4'h4, 32'h0);
        wr(4'hC, 32'h0000_1000);
        repeat (2) @(posedge clk); #1;
        check("R9 masked bit keeps irq low", {31'd0, irq_out}, 32'd0);
        clear_all();
    endtask

    task automatic t_priority();
        @(negedge clk);
        wake_event = 1'b1;
        reg_addr = 4'h8; reg_wdata = 32'h0000_2000; reg_wr = 1'b1;
        @(negedge clk);
        wake_event = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        expect_status("R10 event beats clear", 32'h0000_2000);
        clear_all();
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_regs();
        t_soft_wake();
        t_overrun();
        t_errors();
        t_done();
        t_finished();
        t_irq();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule